// File: doc/BRIEF.md
# Per-Port Power Sequencer

This block runs the power path of one output port through detection, classification and turn-on. A 2-bit operating mode chooses which of those steps are automatic. Auto mode does all three. Semi-auto mode detects and classifies, then waits for a host power-on command. Manual mode does nothing until a command arrives. Off mode keeps the port dark. The block drives the gate enable for the port switch and issues one-cycle request strobes to the detection and classification engines. It also keeps a power-enable status bit and a latched power-good status bit, and emits a one-cycle pulse each time either bit changes.

The states are IDLE, DETECT, CLASSIFY, READY (classified and waiting for a command), START (gate on, waiting for power-good inside a fixed window) and ON. The transitions are:
- IDLE→DETECT: automation with the detect enable set.
- DETECT→CLASSIFY: valid detection with the class enable set.
- DETECT→START or DETECT→READY: valid detection with no classification. Auto goes to START, semi-auto goes to READY.
- CLASSIFY→START or CLASSIFY→READY: valid classification, chosen by the same mode rule.
- DETECT→IDLE and CLASSIFY→IDLE: a failed result, or the mode leaving automation.
- READY→START: the mode becomes auto.
- IDLE/DETECT/CLASSIFY/READY→START: a power-on command in manual or semi-auto mode.
- START→ON: power-good seen.
- START→IDLE: the window expires, with a start-fault pulse.
- Any state→IDLE: off mode, a power-off command or a thermal/undervoltage trip. This turn-off path has the highest priority.

The power-on command takes precedence over automation. Registered outputs change at the clock edge that samples the causing input.

Top module: `port_mode_seq`

## Requirements
- R1: After reset, gate_en, pe_stat, pg_stat, det_req, cls_req, start_fault, pe_chg and pg_chg are all 0.
- R2: With mode 2'b00 (off), no det_req is issued and gate_en stays 0, even with det_en and pwr_on_cmd held high.
- R3: In mode 2'b11 (auto), the block runs the whole sequence without a command. det_req pulses one cycle after det_en is sampled. A passing det_done with cls_en set gives a cls_req pulse. A passing cls_done raises gate_en and pe_stat at the same edge. pg_cmp then sets pg_stat at the next edge.
- R4: In mode 2'b10 (semi-auto), a passing classification leaves gate_en at 0 until a pwr_on_cmd is sampled. gate_en rises at that edge.
- R5: In mode 2'b01 (manual), no det_req is issued. A pwr_on_cmd raises gate_en at the sampling edge.
- R6: With det_en low, no det_req is issued. With cls_en low, a passing detection in auto mode raises gate_en directly, with no cls_req.
- R7: A det_done with result_ok low returns the port to IDLE. With det_en still set, a new det_req pulse follows one edge later.
- R8: If pg_cmp is not seen within START_CYCLES cycles of gate turn-on, gate_en drops and start_fault pulses for one cycle. pg_cmp sampled in the last window cycle still reaches ON, with no start fault.
- R9: pg_stat stays latched after pg_cmp falls and is never 1 without pe_stat.
- R10: A pwr_off_cmd, a fault_trip or mode 2'b00 clears gate_en, pe_stat and pg_stat at the sampling edge. A pwr_off_cmd sampled together with pwr_on_cmd leaves the port off.
- R11: pe_chg and pg_chg each pulse for exactly one cycle whenever pe_stat or pg_stat, respectively, changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 off, 01 manual, 10 semi-auto, 11 auto |
| det_en | input | 1 | Allows detection cycles |
| cls_en | input | 1 | Allows classification after a valid detection |
| det_done | input | 1 | Detection finished strobe |
| cls_done | input | 1 | Classification finished strobe |
| result_ok | input | 1 | Pass flag qualifying det_done / cls_done |
| pg_cmp | input | 1 | Drain-below-threshold comparator |
| fault_trip | input | 1 | Thermal shutdown or supply undervoltage |
| pwr_on_cmd | input | 1 | Power-on command pulse |
| pwr_off_cmd | input | 1 | Power-off command pulse |
| gate_en | output | 1 | Port switch gate enable |
| det_req | output | 1 | One-cycle detection request |
| cls_req | output | 1 | One-cycle classification request |
| start_fault | output | 1 | One-cycle start-window timeout pulse |
| pe_stat | output | 1 | Power-enable status |
| pg_stat | output | 1 | Latched power-good status |
| pe_chg | output | 1 | One-cycle pulse on pe_stat change |
| pg_chg | output | 1 | One-cycle pulse on pg_stat change |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the power-good arrival and the start-window expiry. The bench raises pg_cmp exactly in the final window cycle and expects ON with no start_fault. The second pair is the power-on and power-off commands. The bench drives both in one cycle and expects gate_en to stay low with no change pulse. A port powered through the normal path is then tripped to confirm that the turn-off path wins from every powered state.

// File: rtl/port_seq_pkg.sv
package port_seq_pkg;
    localparam logic [1:0] MODE_OFF    = 2'b00;
    localparam logic [1:0] MODE_MANUAL = 2'b01;
    localparam logic [1:0] MODE_SEMI   = 2'b10;
    localparam logic [1:0] MODE_AUTO   = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DETECT   = 3'd1,
        ST_CLASSIFY = 3'd2,
        ST_READY    = 3'd3,
        ST_START    = 3'd4,
        ST_ON       = 3'd5
    } seq_state_t;
endpackage

// File: rtl/seq_start_window.sv
module seq_start_window #(
    parameter int START_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(START_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(START_CYCLES - 1));

    // R8: the counter never passes the window end
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(START_CYCLES - 1));
endmodule

// File: rtl/seq_status_track.sv
module seq_status_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_d,
    input  logic pg_d,
    output logic pe_stat,
    output logic pg_stat,
    output logic pe_chg,
    output logic pg_chg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_stat <= 1'b0;
            pg_stat <= 1'b0;
            pe_chg  <= 1'b0;
            pg_chg  <= 1'b0;
        end else begin
            pe_stat <= pe_d;
            pg_stat <= pg_d;
            pe_chg  <= (pe_d != pe_stat);
            pg_chg  <= (pg_d != pg_stat);
        end
    end

    p_pe_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pe_stat) || $fell(pe_stat)) |-> pe_chg);
    p_pg_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pg_stat) || $fell(pg_stat)) |-> pg_chg);
    p_pe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pe_chg |-> (pe_stat != $past(pe_stat)));
endmodule

// File: rtl/port_mode_seq.sv
module port_mode_seq
    import port_seq_pkg::*;
#(
    parameter int START_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       det_en,
    input  logic       cls_en,
    input  logic       det_done,
    input  logic       cls_done,
    input  logic       result_ok,
    input  logic       pg_cmp,
    input  logic       fault_trip,
    input  logic       pwr_on_cmd,
    input  logic       pwr_off_cmd,
    output logic       gate_en,
    output logic       det_req,
    output logic       cls_req,
    output logic       start_fault,
    output logic       pe_stat,
    output logic       pg_stat,
    output logic       pe_chg,
    output logic       pg_chg
);
    seq_state_t state, state_d;
    logic off_req, on_cmd_ok, automating, is_auto, win_expired;
    logic pass_next;

    assign off_req    = (mode == MODE_OFF) || fault_trip || pwr_off_cmd;
    assign on_cmd_ok  = pwr_on_cmd && ((mode == MODE_MANUAL) || (mode == MODE_SEMI));
    assign automating = (mode == MODE_SEMI) || (mode == MODE_AUTO);
    assign is_auto    = (mode == MODE_AUTO);

    seq_start_window #(.START_CYCLES(START_CYCLES)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_START),
        .expired (win_expired)
    );

    // next-state logic
    always_comb begin
        state_d   = state;
        pass_next = is_auto;
        if (off_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (on_cmd_ok)                state_d = ST_START;
                    else if (automating && det_en) state_d = ST_DETECT;
                end
                ST_DETECT: begin
                    if (on_cmd_ok)        state_d = ST_START;
                    else if (!automating) state_d = ST_IDLE;
                    else if (det_done) begin
                        if (!result_ok)   state_d = ST_IDLE;
                        else if (cls_en)  state_d = ST_CLASSIFY;
                        else if (pass_next) state_d = ST_START;
                        else              state_d = ST_READY;
                    end
                end
                ST_CLASSIFY: begin
                    if (on_cmd_ok)        state_d = ST_START;
                    else if (!automating) state_d = ST_IDLE;
                    else if (cls_done) begin
                        if (!result_ok)   state_d = ST_IDLE;
                        else if (pass_next) state_d = ST_START;
                        else              state_d = ST_READY;
                    end
                end
                ST_READY: begin
                    if (on_cmd_ok || is_auto) state_d = ST_START;
                    else if (!automating)     state_d = ST_IDLE;
                end
                ST_START: begin
                    if (pg_cmp)           state_d = ST_ON;
                    else if (win_expired) state_d = ST_IDLE;
                end
                ST_ON: state_d = ST_ON;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en     <= 1'b0;
            det_req     <= 1'b0;
            cls_req     <= 1'b0;
            start_fault <= 1'b0;
        end else begin
            gate_en     <= (state_d == ST_START) || (state_d == ST_ON);
            det_req     <= (state_d == ST_DETECT) && (state != ST_DETECT);
            cls_req     <= (state_d == ST_CLASSIFY) && (state != ST_CLASSIFY);
            start_fault <= (state == ST_START) && (state_d == ST_IDLE) && !off_req;
        end
    end

    seq_status_track u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .pe_d    ((state_d == ST_START) || (state_d == ST_ON)),
        .pg_d    (state_d == ST_ON),
        .pe_stat (pe_stat),
        .pg_stat (pg_stat),
        .pe_chg  (pe_chg),
        .pg_chg  (pg_chg)
    );

    p_off_mode_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !gate_en);
    p_det_req_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det_req |-> ($past(mode) != MODE_OFF));
    p_pg_needs_pe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pg_stat |-> pe_stat);
    p_pg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_stat && !off_req) |=> pg_stat);
    p_trip_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_trip || pwr_off_cmd) |=> (!pe_stat && !gate_en));
    p_fault_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_fault |-> (!gate_en && $past(gate_en)));
endmodule

// File: tb/port_mode_seq_test.sv
module port_mode_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic det_en = 0, cls_en = 0, det_done = 0, cls_done = 0, result_ok = 0;
    logic pg_cmp = 0, fault_trip = 0, pwr_on_cmd = 0, pwr_off_cmd = 0;
    logic gate_en, det_req, cls_req, start_fault, pe_stat, pg_stat, pe_chg, pg_chg;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_mode_seq #(.START_CYCLES(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .det_en(det_en), .cls_en(cls_en),
        .det_done(det_done), .cls_done(cls_done), .result_ok(result_ok),
        .pg_cmp(pg_cmp), .fault_trip(fault_trip), .pwr_on_cmd(pwr_on_cmd),
        .pwr_off_cmd(pwr_off_cmd), .gate_en(gate_en), .det_req(det_req),
        .cls_req(cls_req), .start_fault(start_fault), .pe_stat(pe_stat),
        .pg_stat(pg_stat), .pe_chg(pe_chg), .pg_chg(pg_chg)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        mode = 2'b00; det_en = 0; cls_en = 0; det_done = 0; cls_done = 0;
        result_ok = 0; pg_cmp = 0; fault_trip = 0; pwr_on_cmd = 0; pwr_off_cmd = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic t_reset_r1();
        do_reset();
        check("R1", "gate_en", gate_en, 0);
        check("R1", "pe_stat", pe_stat, 0);
        check("R1", "pg_stat", pg_stat, 0);
        check("R1", "det_req", det_req, 0);
        check("R1", "cls_req", cls_req, 0);
        check("R1", "start_fault", start_fault, 0);
        check("R1", "pe_chg", pe_chg, 0);
        check("R1", "pg_chg", pg_chg, 0);
    endtask

    task automatic t_off_mode_r2();
        do_reset();
        mode = 2'b00; det_en = 1; cls_en = 1; pwr_on_cmd = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R2", "det_req", det_req, 0);
            check("R2", "gate_en", gate_en, 0);
        end
        clear_inputs();
    endtask

    task automatic t_auto_r3();
        do_reset();
        mode = 2'b11; det_en = 1; cls_en = 1;
        step();
        check("R3", "det_req pulse", det_req, 1);
        step();
        check("R3", "det_req single", det_req, 0);
        det_done = 1; result_ok = 1;
        step();
        det_done = 0;
        check("R3", "cls_req pulse", cls_req, 1);
        check("R3", "gate off in classify", gate_en, 0);
        cls_done = 1;
        step();
        cls_done = 0;
        check("R3", "gate_en on", gate_en, 1);
        check("R3", "pe_stat on", pe_stat, 1);
        check("R11", "pe_chg rise", pe_chg, 1);
        step();
        check("R11", "pe_chg single", pe_chg, 0);
        check("R3", "pg before cmp", pg_stat, 0);
        pg_cmp = 1;
        step();
        check("R3", "pg_stat set", pg_stat, 1);
        check("R11", "pg_chg rise", pg_chg, 1);
        pg_cmp = 0;
        step();
        check("R9", "pg latched", pg_stat, 1);
        check("R11", "pg_chg single", pg_chg, 0);
        det_en = 0;
        pwr_off_cmd = 1;
        step();
        pwr_off_cmd = 0;
        check("R10", "off gate", gate_en, 0);
        check("R10", "off pe", pe_stat, 0);
        check("R9", "off clears pg", pg_stat, 0);
        check("R11", "pe_chg fall", pe_chg, 1);
        check("R11", "pg_chg fall", pg_chg, 1);
        step();
        check("R11", "pe_chg quiet", pe_chg, 0);
        clear_inputs();
    endtask

    task automatic t_semi_r4();
        do_reset();
        mode = 2'b10; det_en = 1; cls_en = 1;
        step();
        check("R4", "det_req", det_req, 1);
        det_en = 0; det_done = 1; result_ok = 1;
        step();
        det_done = 0;
        cls_done = 1;
        step();
        cls_done = 0;
        for (int i = 0; i < 3; i++) begin
            check("R4", "gate waits", gate_en, 0);
            step();
        end
        check("R4", "gate still waits", gate_en, 0);
        pwr_on_cmd = 1;
        step();
        pwr_on_cmd = 0;
        check("R4", "gate on cmd", gate_en, 1);
        clear_inputs();
    endtask

    task automatic t_manual_r5();
        do_reset();
        mode = 2'b01; det_en = 1; cls_en = 1;
        step();
        check("R5", "no det_req", det_req, 0);
        step();
        check("R5", "no det_req later", det_req, 0);
        pwr_on_cmd = 1;
        step();
        pwr_on_cmd = 0;
        check("R5", "gate on cmd", gate_en, 1);
        check("R5", "pe on cmd", pe_stat, 1);
        fault_trip = 1;
        step();
        fault_trip = 0;
        check("R10", "trip clears gate", gate_en, 0);
        check("R10", "trip clears pe", pe_stat, 0);
        clear_inputs();
    endtask

    task automatic t_enables_r6();
        do_reset();
        mode = 2'b11; det_en = 0; cls_en = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6", "det disabled", det_req, 0);
        end
        det_en = 1;
        step();
        check("R6", "det_req after enable", det_req, 1);
        det_en = 0; det_done = 1; result_ok = 1;
        step();
        det_done = 0;
        check("R6", "skip class cls_req", cls_req, 0);
        check("R6", "skip class gate", gate_en, 1);
        clear_inputs();
    endtask

    task automatic t_retry_r7();
        do_reset();
        mode = 2'b10; det_en = 1; cls_en = 1;
        step();
        check("R7", "first det_req", det_req, 1);
        det_done = 1; result_ok = 0;
        step();
        det_done = 0;
        check("R7", "fail no cls_req", cls_req, 0);
        check("R7", "fail no det_req yet", det_req, 0);
        step();
        check("R7", "retry det_req", det_req, 1);
        clear_inputs();
    endtask

    task automatic t_window_r8();
        do_reset();
        mode = 2'b01;
        pwr_on_cmd = 1;
        step();
        pwr_on_cmd = 0;
        check("R8", "gate on", gate_en, 1);
        for (int i = 1; i < WIN; i++) begin
            step();
            check("R8", "gate in window", gate_en, 1);
        end
        step();
        check("R8", "timeout gate off", gate_en, 0);
        check("R8", "start_fault pulse", start_fault, 1);
        check("R8", "pe cleared", pe_stat, 0);
        step();
        check("R8", "start_fault single", start_fault, 0);
        // late power-good in final window cycle
        pwr_on_cmd = 1;
        step();
        pwr_on_cmd = 0;
        for (int i = 1; i < WIN; i++) step();
        check("R8", "last cycle gate", gate_en, 1);
        pg_cmp = 1;
        step();
        pg_cmp = 0;
        check("R8", "late pg on", gate_en, 1);
        check("R8", "late pg status", pg_stat, 1);
        check("R8", "no start_fault", start_fault, 0);
        clear_inputs();
    endtask

    task automatic t_off_wins_r10();
        do_reset();
        mode = 2'b01;
        pwr_on_cmd = 1; pwr_off_cmd = 1;
        step();
        pwr_on_cmd = 0; pwr_off_cmd = 0;
        check("R10", "on+off stays off", gate_en, 0);
        check("R10", "on+off no pe_chg", pe_chg, 0);
        // mode to off from semi READY-less start
        mode = 2'b10; pwr_on_cmd = 1;
        step();
        pwr_on_cmd = 0;
        check("R10", "semi on", gate_en, 1);
        mode = 2'b00;
        step();
        check("R10", "mode off clears", gate_en, 0);
        check("R10", "mode off pe", pe_stat, 0);
        clear_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_off_mode_r2();
        t_auto_r3();
        t_semi_r4();
        t_manual_r5();
        t_enables_r6();
        t_retry_r7();
        t_window_r8();
        t_off_wins_r10();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule